// File: doc/BRIEF.md
# Receive Completion Tracker

This block keeps the books for a receive path built on two rings of equal size. Host logic posts empty receive buffers into a posting ring, each buffer having a 40-bit address and an opaque context word. The engine fills buffers in posting order. For each filled buffer it writes a status entry with a length, a metadata word and a byte-swap bit into a parallel status ring, then advances its status write index. Slot k of the status ring always describes the buffer posted into slot k of the posting ring, so one read index serves both rings.

The consumer pops completions one at a time. A pop succeeds only when the engine has committed an entry past the read index and that entry's length is no longer zero. A zero length means the index update arrived before the entry contents. A successful pop returns the status fields together with the context of the buffer in the same slot, clears the length and the context slot, and advances the read index. A revoke drains buffers that were posted but never filled. It returns their contexts in posting order and fails at the first empty slot. Request outcomes (`enq_ok_o`, `pop_ok_o`, `rvk_ok_o`) are combinational in the request cycle, and state changes at the following clock edge.

Top module: `rxc_completion_tracker`

## Requirements
- R1: While reset is held, `done_cnt_o` is 0, `pop_ok_o` and `rvk_ok_o` stay low even when requested, and an enqueue request is accepted.
- R2: An enqueue is accepted (`enq_ok_o` high in the request cycle) exactly when fewer than DEPTH buffers are posted. A refused enqueue changes no stored address, context or index.
- R3: The k-th accepted buffer since reset occupies slot k mod DEPTH. Reading that slot on `eng_idx_i` gives address bits 31:0 on `eng_addr_lo_o` and bits 39:32 on `eng_addr_hi_o`.
- R4: `done_cnt_o` equals the status write index minus the read index. The status write index advances by one for each `st_commit_i` cycle and for each successful revoke. The read index advances by one for each successful pop or revoke.
- R5: A pop succeeds only when `done_cnt_o` is non-zero and the length stored at the read slot is non-zero. A failed pop leaves both indices unchanged.
- R6: In a successful pop cycle, `pop_len_o`, `pop_meta_o` and `head_ctx_o` carry the read slot's length, metadata and posted context. `pop_swapped_o` equals the byte-swap bit the engine wrote.
- R7: A successful pop writes the read slot's length back to zero, unless the engine writes that slot in the same cycle. A later commit of that slot with no new length write therefore still fails to pop.
- R8: Each successful pop or revoke advances the read index by one modulo DEPTH and frees one posting slot for enqueue.
- R9: A revoke succeeds when `pop_i` is low, `st_commit_i` is low, `done_cnt_o` is 0 and the read slot holds a posted context. It then presents that context on `head_ctx_o`, empties the slot and advances both indices. In all other cases it fails, and an empty slot marks the end of a drain.
- R10: When `pop_i` and `rvk_i` are both high, the revoke never succeeds in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Post a receive buffer |
| enq_addr_i | input | 32+ADDR_HI_W | Buffer address |
| enq_ctx_i | input | CTX_W | Buffer context |
| enq_ok_o | output | 1 | Enqueue accepted this cycle |
| eng_idx_i | input | log2(DEPTH) | Slot whose buffer address the engine reads |
| eng_addr_lo_o | output | 32 | Address low word of that slot |
| eng_addr_hi_o | output | ADDR_HI_W | Address high field of that slot |
| st_we_i | input | 1 | Engine writes a status entry |
| st_idx_i | input | log2(DEPTH) | Status slot written |
| st_len_i | input | LEN_W | Filled length |
| st_meta_i | input | META_W | Metadata |
| st_swap_i | input | 1 | Byte-swap bit |
| st_commit_i | input | 1 | Advance engine status write index by one |
| done_cnt_o | output | log2(DEPTH)+1 | Committed entries not yet consumed |
| pop_i | input | 1 | Pop request |
| pop_ok_o | output | 1 | Pop succeeds this cycle |
| pop_len_o | output | LEN_W | Length at read slot |
| pop_meta_o | output | META_W | Metadata at read slot |
| pop_swapped_o | output | 1 | Swapped flag at read slot |
| rvk_i | input | 1 | Revoke request |
| rvk_ok_o | output | 1 | Revoke succeeds this cycle |
| head_ctx_o | output | CTX_W | Context at read slot |

## Verification
The bench builds the tracker with DEPTH=4 and 8-bit context, length and metadata fields. With a ring that small, six rounds of fill, complete and drain wrap both indices several times. Every slot is reused after its length was cleared, and the full-ring refusal is hit in every round. In alternate rounds the engine commits before writing the length, and then writes the length before committing. This covers the zero-length race, a pop with nothing committed, and revoke refusal while a completion is pending. Expected indices, counts and slot contents come from an arithmetic model in the bench.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int ADDR_LO_W = 32;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_POP,
    RD_RVK
  } rd_op_e;
endpackage

// File: rtl/rxc_post_ring.sv
module rxc_post_ring #(
  parameter int DEPTH     = 16,
  parameter int CTX_W     = 32,
  parameter int ADDR_HI_W = 8,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int PW       = IDX_W + 1,
  localparam int ADDR_W   = rxc_pkg::ADDR_LO_W + ADDR_HI_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enq_valid_i,
  input  logic [ADDR_W-1:0]    enq_addr_i,
  input  logic [CTX_W-1:0]     enq_ctx_i,
  output logic                 enq_ok_o,
  input  logic [PW-1:0]        rd_ptr_i,
  input  logic                 release_i,
  input  logic [IDX_W-1:0]     eng_idx_i,
  output logic [rxc_pkg::ADDR_LO_W-1:0] eng_addr_lo_o,
  output logic [ADDR_HI_W-1:0] eng_addr_hi_o,
  output logic [CTX_W-1:0]     head_ctx_o,
  output logic                 head_vld_o
);
  localparam int LO_W = rxc_pkg::ADDR_LO_W;

  logic [PW-1:0]    wr_q;
  logic [PW-1:0]    used;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  logic [LO_W-1:0]      lo_a  [DEPTH];
  logic [ADDR_HI_W-1:0] hi_a  [DEPTH];
  logic [CTX_W-1:0]     ctx_a [DEPTH];
  logic                 vld_a [DEPTH];

  assign wr_idx   = wr_q[IDX_W-1:0];
  assign rd_idx   = rd_ptr_i[IDX_W-1:0];
  assign used     = wr_q - rd_ptr_i;
  assign enq_ok_o = enq_valid_i && (used != PW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wr_q <= '0;
    else if (enq_ok_o) wr_q <= wr_q + PW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [LO_W-1:0]      lo_r;
    logic [ADDR_HI_W-1:0] hi_r;
    logic [CTX_W-1:0]     ctx_r;
    logic                 vld_r;
    logic                 set_w, clr_w;

    assign set_w = enq_ok_o && (wr_idx == IDX_W'(i));
    assign clr_w = release_i && (rd_idx == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_r  <= '0;
        hi_r  <= '0;
        ctx_r <= '0;
        vld_r <= 1'b0;
      end else if (set_w) begin
        lo_r  <= enq_addr_i[LO_W-1:0];
        hi_r  <= enq_addr_i[ADDR_W-1:LO_W];
        ctx_r <= enq_ctx_i;
        vld_r <= 1'b1;
      end else if (clr_w) begin
        ctx_r <= '0;
        vld_r <= 1'b0;
      end
    end

    assign lo_a[i]  = lo_r;
    assign hi_a[i]  = hi_r;
    assign ctx_a[i] = ctx_r;
    assign vld_a[i] = vld_r;
  end

  assign eng_addr_lo_o = lo_a[eng_idx_i];
  assign eng_addr_hi_o = hi_a[eng_idx_i];
  assign head_ctx_o    = ctx_a[rd_idx];
  assign head_vld_o    = vld_a[rd_idx];

  // R2: posted count never exceeds ring size
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= PW'(DEPTH));
endmodule

// File: rtl/rxc_status_ring.sv
module rxc_status_ring #(
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 16,
  parameter int META_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PW    = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_we_i,
  input  logic [IDX_W-1:0]  st_idx_i,
  input  logic [LEN_W-1:0]  st_len_i,
  input  logic [META_W-1:0] st_meta_i,
  input  logic              st_swap_i,
  input  logic              st_commit_i,
  input  logic              skip_i,
  input  logic              clear_i,
  input  logic [PW-1:0]     rd_ptr_i,
  output logic [LEN_W-1:0]  head_len_o,
  output logic [META_W-1:0] head_meta_o,
  output logic              head_swap_o,
  output logic [PW-1:0]     done_cnt_o
);
  logic [PW-1:0]    wp_q;
  logic [IDX_W-1:0] rd_idx;

  logic [LEN_W-1:0]  len_a  [DEPTH];
  logic [META_W-1:0] meta_a [DEPTH];
  logic              swap_a [DEPTH];

  assign rd_idx     = rd_ptr_i[IDX_W-1:0];
  assign done_cnt_o = wp_q - rd_ptr_i;

  // revoke skips an unfilled slot so both rings stay aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    wp_q <= '0;
    else if (st_commit_i || skip_i) wp_q <= wp_q + PW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [LEN_W-1:0]  len_r;
    logic [META_W-1:0] meta_r;
    logic              swap_r;
    logic              wr_w;

    assign wr_w = st_we_i && (st_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        len_r  <= '0;
        meta_r <= '0;
        swap_r <= 1'b0;
      end else if (wr_w) begin
        len_r  <= st_len_i;
        meta_r <= st_meta_i;
        swap_r <= st_swap_i;
      end else if (clear_i && (rd_idx == IDX_W'(i))) begin
        len_r  <= '0;
      end
    end

    assign len_a[i]  = len_r;
    assign meta_a[i] = meta_r;
    assign swap_a[i] = swap_r;
  end

  assign head_len_o  = len_a[rd_idx];
  assign head_meta_o = meta_a[rd_idx];
  assign head_swap_o = swap_a[rd_idx];

  // R7: consumed entry cannot be consumed again
  p_len_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !(st_we_i && (st_idx_i == rd_idx))) |=> (len_a[$past(rd_idx)] == '0));

  // R4: committed backlog bounded by ring size
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_cnt_o <= PW'(DEPTH));
endmodule

// File: rtl/rxc_read_ctrl.sv
module rxc_read_ctrl #(
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PW    = IDX_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          rvk_i,
  input  logic          st_commit_i,
  input  logic [PW-1:0] done_cnt_i,
  input  logic          head_len_nz_i,
  input  logic          head_vld_i,
  output logic          pop_ok_o,
  output logic          rvk_ok_o,
  output logic [PW-1:0] rd_ptr_o
);
  import rxc_pkg::*;

  rd_op_e        op;
  logic [PW-1:0] rd_q;

  // pop owns the cycle; revoke only drains unfilled slots
  always_comb begin
    op = RD_NONE;
    if (pop_i) begin
      if ((done_cnt_i != '0) && head_len_nz_i) op = RD_POP;
    end else if (rvk_i && !st_commit_i && (done_cnt_i == '0) && head_vld_i) begin
      op = RD_RVK;
    end
  end

  assign pop_ok_o = (op == RD_POP);
  assign rvk_ok_o = (op == RD_RVK);
  assign rd_ptr_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rd_q <= '0;
    else if (op != RD_NONE)  rd_q <= rd_q + PW'(1);
  end

  // R5: failed pop does not move the read index
  p_hold_on_fail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !pop_ok_o) |=> $stable(rd_q));

  // R8: each completion or revoke moves exactly one slot
  p_advance_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_ok_o || rvk_ok_o) |=> (rd_q == $past(rd_q) + PW'(1)));
endmodule

// File: rtl/rxc_completion_tracker.sv
module rxc_completion_tracker #(
  parameter int DEPTH     = 16,
  parameter int CTX_W     = 32,
  parameter int LEN_W     = 16,
  parameter int META_W    = 32,
  parameter int ADDR_HI_W = 8,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int PW       = IDX_W + 1,
  localparam int ADDR_W   = rxc_pkg::ADDR_LO_W + ADDR_HI_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enq_valid_i,
  input  logic [ADDR_W-1:0]    enq_addr_i,
  input  logic [CTX_W-1:0]     enq_ctx_i,
  output logic                 enq_ok_o,
  input  logic [IDX_W-1:0]     eng_idx_i,
  output logic [rxc_pkg::ADDR_LO_W-1:0] eng_addr_lo_o,
  output logic [ADDR_HI_W-1:0] eng_addr_hi_o,
  input  logic                 st_we_i,
  input  logic [IDX_W-1:0]     st_idx_i,
  input  logic [LEN_W-1:0]     st_len_i,
  input  logic [META_W-1:0]    st_meta_i,
  input  logic                 st_swap_i,
  input  logic                 st_commit_i,
  output logic [PW-1:0]        done_cnt_o,
  input  logic                 pop_i,
  output logic                 pop_ok_o,
  output logic [LEN_W-1:0]     pop_len_o,
  output logic [META_W-1:0]    pop_meta_o,
  output logic                 pop_swapped_o,
  input  logic                 rvk_i,
  output logic                 rvk_ok_o,
  output logic [CTX_W-1:0]     head_ctx_o
);
  logic [PW-1:0] rd_ptr;
  logic          head_vld;
  logic          release_w;

  assign release_w = pop_ok_o || rvk_ok_o;

  rxc_post_ring #(
    .DEPTH(DEPTH), .CTX_W(CTX_W), .ADDR_HI_W(ADDR_HI_W)
  ) u_post (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enq_valid_i   (enq_valid_i),
    .enq_addr_i    (enq_addr_i),
    .enq_ctx_i     (enq_ctx_i),
    .enq_ok_o      (enq_ok_o),
    .rd_ptr_i      (rd_ptr),
    .release_i     (release_w),
    .eng_idx_i     (eng_idx_i),
    .eng_addr_lo_o (eng_addr_lo_o),
    .eng_addr_hi_o (eng_addr_hi_o),
    .head_ctx_o    (head_ctx_o),
    .head_vld_o    (head_vld)
  );

  rxc_status_ring #(
    .DEPTH(DEPTH), .LEN_W(LEN_W), .META_W(META_W)
  ) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .st_we_i     (st_we_i),
    .st_idx_i    (st_idx_i),
    .st_len_i    (st_len_i),
    .st_meta_i   (st_meta_i),
    .st_swap_i   (st_swap_i),
    .st_commit_i (st_commit_i),
    .skip_i      (rvk_ok_o),
    .clear_i     (pop_ok_o),
    .rd_ptr_i    (rd_ptr),
    .head_len_o  (pop_len_o),
    .head_meta_o (pop_meta_o),
    .head_swap_o (pop_swapped_o),
    .done_cnt_o  (done_cnt_o)
  );

  rxc_read_ctrl #(
    .DEPTH(DEPTH)
  ) u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pop_i         (pop_i),
    .rvk_i         (rvk_i),
    .st_commit_i   (st_commit_i),
    .done_cnt_i    (done_cnt_o),
    .head_len_nz_i (|pop_len_o),
    .head_vld_i    (head_vld),
    .pop_ok_o      (pop_ok_o),
    .rvk_ok_o      (rvk_ok_o),
    .rd_ptr_o      (rd_ptr)
  );

  // R6: every completion pairs with a posted buffer
  p_pop_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok_o |-> head_vld);

  // R9: revoke keeps status index in step with read index
  p_rvk_sync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvk_ok_o |=> (done_cnt_o == '0));
endmodule

// File: tb/sim_rxc_completion_tracker.sv
`timescale 1ns/1ps
module sim_rxc_completion_tracker;
  localparam int D  = 4;
  localparam int IW = 2;
  localparam int PW = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic        enq_valid_i;
  logic [39:0] enq_addr_i;
  logic [7:0]  enq_ctx_i;
  logic        enq_ok_o;
  logic [IW-1:0] eng_idx_i;
  logic [31:0] eng_addr_lo_o;
  logic [7:0]  eng_addr_hi_o;
  logic        st_we_i;
  logic [IW-1:0] st_idx_i;
  logic [7:0]  st_len_i;
  logic [7:0]  st_meta_i;
  logic        st_swap_i;
  logic        st_commit_i;
  logic [PW-1:0] done_cnt_o;
  logic        pop_i, pop_ok_o, pop_swapped_o;
  logic [7:0]  pop_len_o, pop_meta_o;
  logic        rvk_i, rvk_ok_o;
  logic [7:0]  head_ctx_o;

  rxc_completion_tracker #(
    .DEPTH(D), .CTX_W(8), .LEN_W(8), .META_W(8), .ADDR_HI_W(8)
  ) u0 (.*);

  int total = 0, bad = 0;
  int wr = 0, rd = 0, sw = 0;
  bit          m_vld [D];
  logic [7:0]  m_ctx [D];
  logic [39:0] m_addr[D];
  logic [7:0]  m_len [D];
  logic [7:0]  m_meta[D];
  bit          m_swap[D];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    enq_valid_i = 0; enq_addr_i = '0; enq_ctx_i = '0; eng_idx_i = '0;
    st_we_i = 0; st_idx_i = '0; st_len_i = '0; st_meta_i = '0; st_swap_i = 0;
    st_commit_i = 0; pop_i = 0; rvk_i = 0;
  endtask

  task automatic t_enq(input logic [39:0] a, input logic [7:0] c);
    bit ok;
    @(negedge clk_i); clr();
    enq_valid_i = 1; enq_addr_i = a; enq_ctx_i = c;
    #1;
    ok = (wr - rd) < D;
    chk("R2 R8 enqueue acceptance", enq_ok_o, ok);
    @(posedge clk_i);
    if (ok) begin
      m_vld[wr%D] = 1; m_ctx[wr%D] = c; m_addr[wr%D] = a; wr++;
    end
  endtask

  task automatic t_addr(input int i);
    @(negedge clk_i); clr();
    eng_idx_i = IW'(i);
    #1;
    chk("R3 address low word", eng_addr_lo_o, m_addr[i][31:0]);
    chk("R3 address high field", eng_addr_hi_o, m_addr[i][39:32]);
  endtask

  task automatic t_eng(input bit we, input int idx, input logic [7:0] len,
                       input logic [7:0] meta, input bit swp, input bit commit);
    @(negedge clk_i); clr();
    st_we_i = we; st_idx_i = IW'(idx); st_len_i = len; st_meta_i = meta;
    st_swap_i = swp; st_commit_i = commit;
    #1;
    chk("R4 done count", done_cnt_o, PW'(sw - rd));
    @(posedge clk_i);
    if (we) begin m_len[idx] = len; m_meta[idx] = meta; m_swap[idx] = swp; end
    if (commit) sw++;
  endtask

  task automatic t_pop(input bit with_rvk);
    int s;
    bit ok;
    @(negedge clk_i); clr();
    pop_i = 1; rvk_i = with_rvk;
    #1;
    s = rd % D;
    ok = ((sw - rd) > 0) && (m_len[s] != 0);
    chk("R5 pop outcome", pop_ok_o, ok);
    if (with_rvk) chk("R10 revoke blocked by pop", rvk_ok_o, 0);
    if (ok) begin
      chk("R6 pop length", pop_len_o, m_len[s]);
      chk("R6 pop metadata", pop_meta_o, m_meta[s]);
      chk("R6 pop swapped", pop_swapped_o, m_swap[s]);
      chk("R6 pop context", head_ctx_o, m_ctx[s]);
    end
    @(posedge clk_i);
    if (ok) begin m_len[s] = 0; m_vld[s] = 0; rd++; end
  endtask

  task automatic t_rvk();
    int s;
    bit ok;
    @(negedge clk_i); clr();
    rvk_i = 1;
    #1;
    s = rd % D;
    ok = (sw == rd) && m_vld[s];
    chk("R9 revoke outcome", rvk_ok_o, ok);
    if (ok) chk("R9 revoke context", head_ctx_o, m_ctx[s]);
    @(posedge clk_i);
    if (ok) begin m_vld[s] = 0; rd++; sw++; end
  endtask

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) begin
      m_vld[i] = 0; m_ctx[i] = '0; m_addr[i] = '0;
      m_len[i] = '0; m_meta[i] = '0; m_swap[i] = 0;
    end
    clr();
    repeat (3) @(negedge clk_i);
    pop_i = 1; #1;
    chk("R1 reset pop", pop_ok_o, 0);
    chk("R1 reset count", done_cnt_o, 0);
    pop_i = 0; rvk_i = 1; #1;
    chk("R1 reset revoke", rvk_ok_o, 0);
    rvk_i = 0; enq_valid_i = 1; #1;
    chk("R1 reset enqueue", enq_ok_o, 1);
    clr();
    @(negedge clk_i); rst_ni = 1;

    for (int r = 0; r < 6; r++) begin
      int ncomp;
      for (int k = 0; k <= D; k++)
        t_enq({8'(r*17 + k + 1), 32'(r*32'h0101_0101 + k*32'h1000_0003)}, 8'(r*16 + k + 1));
      for (int i = 0; i < D; i++)
        if (m_vld[i]) t_addr(i);
      ncomp = (r % D) + 1;
      for (int c = 0; c < ncomp; c++) begin
        int s;
        logic [7:0] len, meta;
        bit swp;
        s = sw % D;
        len = 8'((r*37 + c*11) % 255 + 1);
        meta = 8'(r*5 + c + 8'h40);
        swp = ((r + c) % 2) == 1;
        if (r % 2) begin
          // index update lands before the length (R7 zero-length race)
          t_eng(0, s, 0, 0, 0, 1);
          t_pop(0);
          t_rvk();
          t_eng(1, s, len, meta, swp, 0);
          t_pop(0);
        end else begin
          t_eng(1, s, len, meta, swp, 0);
          t_pop(1);
          t_eng(0, s, 0, 0, 0, 1);
          t_pop(0);
        end
      end
      if (r % 3 == 2)
        for (int j = 0; j <= D; j++) t_rvk();
    end
    for (int j = 0; j <= D; j++) t_rvk();
    t_eng(0, 0, 0, 0, 0, 0);
    @(negedge clk_i); clr();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule